// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit serves the table lookup step of a small 8-bit controller. Software keeps an 8-bit lookup pointer in a register in data space. A read command picks a 256-word page, either the page that the program counter is on now or the last page of the 4K-word program store. The unit then reads one 15-bit program word through a synchronous-read port. The low byte goes to the data memory location named by the command. The upper seven bits land in a read-only high-byte register, whose top bit is always zero.

A command is offered with a valid/ready handshake. The unit takes it only when idle, which is when `cmd_ready` is high. The low byte leaves through a valid/ready write port. When the data memory holds `dm_wready` low, the write waits and keeps its address and data stable. The read does not complete, and the high-byte register does not change, until that write is taken. `busy` marks the unit as occupied. The two registers are reached through a plain byte-wide register port that shares the data address space.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the lookup pointer and the high-byte register both read 0x00, and `busy`, `pm_req` and `dm_wvalid` are low.
- R2: A register write to data address 0x07 loads the lookup pointer. Reads of 0x07 return it in the same cycle. Reads of any address other than 0x07 and 0x08 return 0x00.
- R3: Register writes to data address 0x08 have no effect. Reading 0x08 still returns the previous high-byte value.
- R4: When a command is taken with `cmd_last` = 0, the program address is {pc[11:8], pointer}. Both values are sampled in the acceptance cycle. A pointer write in that same cycle affects only later commands.
- R5: When a command is taken with `cmd_last` = 1, the program address is {4'hF, pointer}.
- R6: `pm_req` is high for exactly one cycle, the cycle after acceptance, with `pm_addr` valid. `dm_wvalid` rises in the next cycle, so an unstalled read takes two cycles.
- R7: `dm_wdata` equals bits 7..0 of the fetched word, and `dm_waddr` equals the `cmd_dst` captured at acceptance.
- R8: When the write handshakes, the high-byte register takes {1'b0, word[14:8]}. Bit 7 always reads 0.
- R9: `busy` is high from the cycle after acceptance until the write handshake, and `cmd_ready` is its inverse. A command offered while busy is not taken and starts no fetch.
- R10: While `dm_wvalid` is high and `dm_wready` is low, `dm_wvalid`, `dm_waddr` and `dm_wdata` hold steady, even if the program port output changes meanwhile.
- R11: The high-byte register changes only in the cycle that follows a write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc | input | 12 | Current program counter |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_last | input | 1 | 1 selects the last page, 0 the current page |
| cmd_dst | input | 8 | Data address for the low byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register data address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pm_req | output | 1 | Program store read request |
| pm_addr | output | 12 | Program store word address |
| pm_rdata | input | 15 | Program word, valid the cycle after `pm_req` |
| dm_wvalid | output | 1 | Low-byte write offered |
| dm_wready | input | 1 | Data memory takes the write |
| dm_waddr | output | 8 | Low-byte destination address |
| dm_wdata | output | 8 | Low byte of the fetched word |
| busy | output | 1 | Read in progress |

## Verification
A wrong page or pointer latch shows up at `pm_addr` in the cycle right after acceptance, and the bad word reaches `dm_wdata` one cycle later. A wrong sequencer state appears within a cycle as a mistimed `pm_req`, `dm_wvalid` or `busy`. A failure to hold the word during back-pressure shows as `dm_wdata` changing during a stall. A wrong high-byte update can be read at address 0x08 in the cycle after the handshake, or whenever a write to 0x08 is offered.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;

endpackage

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int PC_W  = 12,
  parameter int PTR_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [PTR_W-1:0] ptr,
  input  logic             last,
  output logic [PC_W-1:0]  addr
);
  localparam int PG_W = PC_W - PTR_W;

  logic [PG_W-1:0] page;

  // Page bits: forced all-ones for the final page, else from the PC.
  always_comb begin
    page = last ? {PG_W{1'b1}} : pc[PC_W-1:PTR_W];
    addr = {page, ptr};
  end
endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs #(
  parameter int            DATA_W   = 8,
  parameter int            DADDR_W  = 8,
  parameter int            WORD_W   = 15,
  parameter logic [7:0]    PTR_ADDR = 8'h07,
  parameter logic [7:0]    HI_ADDR  = 8'h08
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [DADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               hi_load,
  input  logic [WORD_W-1:0]  word,
  output logic [DATA_W-1:0]  ptr,
  output logic [DATA_W-1:0]  hi
);
  localparam int UP_W = WORD_W - DATA_W;

  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] hi_next;

  // Upper word bits into the high byte; missing bits read as zero.
  generate
    if (UP_W >= DATA_W) begin : g_trunc
      assign hi_next = word[DATA_W +: DATA_W];
    end else begin : g_pad
      assign hi_next = {{(DATA_W-UP_W){1'b0}}, word[WORD_W-1:DATA_W]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      hi_q  <= '0;
    end else begin
      if (reg_we && reg_addr == DADDR_W'(PTR_ADDR))
        ptr_q <= reg_wdata;
      if (hi_load)
        hi_q <= hi_next;
    end
  end

  always_comb begin
    if (reg_addr == DADDR_W'(PTR_ADDR))
      reg_rdata = ptr_q;
    else if (reg_addr == DADDR_W'(HI_ADDR))
      reg_rdata = hi_q;
    else
      reg_rdata = '0;
  end

  assign ptr = ptr_q;
  assign hi  = hi_q;
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int WORD_W  = 15,
  parameter int DATA_W  = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [DADDR_W-1:0] cmd_dst,
  input  logic [PC_W-1:0]    addr_in,
  output logic               pm_req,
  output logic [PC_W-1:0]    pm_addr,
  input  logic [WORD_W-1:0]  pm_rdata,
  output logic               dm_wvalid,
  input  logic               dm_wready,
  output logic [DADDR_W-1:0] dm_waddr,
  output logic [DATA_W-1:0]  dm_wdata,
  output logic               done,
  output logic [WORD_W-1:0]  word,
  output logic               busy
);
  seq_state_t         state_q;
  logic [PC_W-1:0]    addr_q;
  logic [DADDR_W-1:0] dst_q;
  logic [WORD_W-1:0]  word_q;
  logic               fresh_q;
  logic               accept;

  assign cmd_ready = (state_q == SEQ_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = !cmd_ready;
  assign pm_req    = (state_q == SEQ_FETCH);
  assign pm_addr   = addr_q;
  assign dm_wvalid = (state_q == SEQ_WRITE);
  assign dm_waddr  = dst_q;
  // The port output is used directly in the first write cycle, the held copy after.
  assign word      = fresh_q ? pm_rdata : word_q;
  assign dm_wdata  = word[DATA_W-1:0];
  assign done      = dm_wvalid && dm_wready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      dst_q   <= '0;
      word_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            addr_q  <= addr_in;
            dst_q   <= cmd_dst;
            state_q <= SEQ_FETCH;
          end
        end
        SEQ_FETCH: begin
          fresh_q <= 1'b1;
          state_q <= SEQ_WRITE;
        end
        SEQ_WRITE: begin
          if (fresh_q) begin
            word_q  <= pm_rdata;
            fresh_q <= 1'b0;
          end
          if (dm_wready)
            state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int         PC_W     = 12,
  parameter int         PTR_W    = 8,
  parameter int         WORD_W   = 15,
  parameter int         DATA_W   = 8,
  parameter int         DADDR_W  = 8,
  parameter logic [7:0] PTR_ADDR = 8'h07,
  parameter logic [7:0] HI_ADDR  = 8'h08
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    pc,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_last,
  input  logic [DADDR_W-1:0] cmd_dst,
  input  logic               reg_we,
  input  logic [DADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               pm_req,
  output logic [PC_W-1:0]    pm_addr,
  input  logic [WORD_W-1:0]  pm_rdata,
  output logic               dm_wvalid,
  input  logic               dm_wready,
  output logic [DADDR_W-1:0] dm_waddr,
  output logic [DATA_W-1:0]  dm_wdata,
  output logic               busy
);
  logic [DATA_W-1:0] ptr_w;
  logic [DATA_W-1:0] hi_w;
  logic [PC_W-1:0]   addr_w;
  logic [WORD_W-1:0] word_w;
  logic              done_w;

  tblrd_addr #(.PC_W(PC_W), .PTR_W(PTR_W)) i_addr (
    .pc   (pc),
    .ptr  (ptr_w[PTR_W-1:0]),
    .last (cmd_last),
    .addr (addr_w)
  );

  tblrd_seq #(
    .PC_W(PC_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .DADDR_W(DADDR_W)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_dst   (cmd_dst),
    .addr_in   (addr_w),
    .pm_req    (pm_req),
    .pm_addr   (pm_addr),
    .pm_rdata  (pm_rdata),
    .dm_wvalid (dm_wvalid),
    .dm_wready (dm_wready),
    .dm_waddr  (dm_waddr),
    .dm_wdata  (dm_wdata),
    .done      (done_w),
    .word      (word_w),
    .busy      (busy)
  );

  tblrd_regs #(
    .DATA_W(DATA_W), .DADDR_W(DADDR_W), .WORD_W(WORD_W),
    .PTR_ADDR(PTR_ADDR), .HI_ADDR(HI_ADDR)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hi_load   (done_w),
    .word      (word_w),
    .ptr       (ptr_w),
    .hi        (hi_w)
  );
endmodule

// File: rtl/tblrd_chk.sv
module tblrd_chk #(
  parameter int PC_W    = 12,
  parameter int DATA_W  = 8,
  parameter int DADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               pm_req,
  input logic               dm_wvalid,
  input logic               dm_wready,
  input logic [DADDR_W-1:0] dm_waddr,
  input logic [DATA_W-1:0]  dm_wdata,
  input logic               busy,
  input logic [DATA_W-1:0]  hi
);
  // R6
  fetch_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> pm_req);

  // R6
  write_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req |=> (dm_wvalid && !pm_req));

  // R9
  ready_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R9
  fetch_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req || dm_wvalid) |-> busy);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_wvalid && !dm_wready) |=>
      (dm_wvalid && $stable(dm_waddr) && $stable(dm_wdata)));

  // R11
  hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_wvalid && dm_wready) |=> $stable(hi));

  // R8
  hi_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi[DATA_W-1]);
endmodule

bind tblrd_unit tblrd_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .DADDR_W(DADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .pm_req    (pm_req),
  .dm_wvalid (dm_wvalid),
  .dm_wready (dm_wready),
  .dm_waddr  (dm_waddr),
  .dm_wdata  (dm_wdata),
  .busy      (busy),
  .hi        (hi_w)
);

// File: tb/test_tblrd_unit.sv
`timescale 1ns/1ps
module test_tblrd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pc = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_last = 1'b0;
  logic [7:0]  cmd_dst = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        pm_req;
  logic [11:0] pm_addr;
  logic [14:0] pm_rdata = '0;
  logic        dm_wvalid;
  logic        dm_wready = 1'b1;
  logic [7:0]  dm_waddr;
  logic [7:0]  dm_wdata;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = !clk;

  tblrd_unit i_tblrd_unit (
    .clk(clk), .rst_n(rst_n), .pc(pc), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_last(cmd_last), .cmd_dst(cmd_dst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pm_req(pm_req), .pm_addr(pm_addr),
    .pm_rdata(pm_rdata), .dm_wvalid(dm_wvalid), .dm_wready(dm_wready),
    .dm_waddr(dm_waddr), .dm_wdata(dm_wdata), .busy(busy)
  );

  function automatic logic [14:0] rom(input logic [11:0] a);
    int v;
    v = (int'(a) * 211) ^ (int'(a) << 3) ^ 32'h2C5B;
    return v[14:0];
  endfunction

  // Program store: registered read on request; output scrambles otherwise.
  always @(posedge clk) begin
    if (pm_req) pm_rdata <= rom(pm_addr);
    else        pm_rdata <= pm_rdata ^ 15'h5A5A;
  end

  // Reference model: 0 idle, 1 fetch, 2 write.
  int          m_st = 0;
  logic [7:0]  m_ptr = '0;
  logic [7:0]  m_hi = '0;
  logic [11:0] m_addr = '0;
  logic [7:0]  m_dst = '0;
  logic        m_last = 1'b0;
  logic        m_stalled = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = '0; m_hi = '0; m_stalled = 1'b0;
    end else begin
      m_stalled = 1'b0;
      if (m_st == 0) begin
        if (cmd_valid) begin
          m_addr = cmd_last ? {4'hF, m_ptr} : {pc[11:8], m_ptr};
          m_last = cmd_last;
          m_dst  = cmd_dst;
          m_st   = 1;
        end
      end else if (m_st == 1) begin
        m_st = 2;
      end else if (dm_wready) begin
        m_hi = {1'b0, rom(m_addr)[14:8]};
        m_st = 0;
      end else begin
        m_stalled = 1'b1;
      end
      if (reg_we && reg_addr == 8'h07) m_ptr = reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Compare every cycle on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R9 busy", 32'(busy), 32'(m_st != 0));
      chk("R9 cmd_ready", 32'(cmd_ready), 32'(m_st == 0));
      chk("R6 pm_req", 32'(pm_req), 32'(m_st == 1));
      chk("R6 dm_wvalid", 32'(dm_wvalid), 32'(m_st == 2));
      if (m_st == 1)
        chk(m_last ? "R5 pm_addr" : "R4 pm_addr", 32'(pm_addr), 32'(m_addr));
      if (m_st == 2) begin
        chk(m_stalled ? "R10 dm_wdata" : "R7 dm_wdata", 32'(dm_wdata), 32'(rom(m_addr)[7:0]));
        chk(m_stalled ? "R10 dm_waddr" : "R7 dm_waddr", 32'(dm_waddr), 32'(m_dst));
      end
      if (reg_addr == 8'h07)      chk("R2 ptr read", 32'(reg_rdata), 32'(m_ptr));
      else if (reg_addr == 8'h08) chk("R8 R11 hi read", 32'(reg_rdata), 32'(m_hi));
      else                        chk("R2 unmapped read", 32'(reg_rdata), 32'h0);
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_we = 1'b0;
  endtask

  task automatic issue(input logic last, input logic [11:0] p, input logic [7:0] dst);
    cmd_valid = 1'b1; cmd_last = last; pc = p; cmd_dst = dst;
    step(); cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: state right after reset release
    reg_addr = 8'h07; #1; chk("R1 ptr reset", 32'(reg_rdata), 32'h0);
    reg_addr = 8'h08; #1; chk("R1 hi reset", 32'(reg_rdata), 32'h0);
    chk("R1 busy reset", 32'(busy), 32'h0);
    chk("R1 pm_req reset", 32'(pm_req), 32'h0);
    chk("R1 dm_wvalid reset", 32'(dm_wvalid), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step();

    // R2 pointer write/read, R3 high-byte write ignored
    wr_reg(8'h07, 8'h3C);
    reg_addr = 8'h07; step();
    wr_reg(8'h08, 8'h55);
    reg_addr = 8'h08; step();

    // R4 current-page read, page 0xA
    issue(1'b0, 12'hA17, 8'h40);
    reg_addr = 8'h08; repeat (4) step();
    // R5 last-page read with a new pointer
    wr_reg(8'h07, 8'hFF);
    issue(1'b1, 12'h123, 8'h41);
    repeat (4) step();

    // R9 command held while busy; R10 stall for several cycles
    dm_wready = 1'b0;
    cmd_valid = 1'b1; cmd_last = 1'b0; pc = 12'h5FF; cmd_dst = 8'h20;
    repeat (4) step();
    cmd_valid = 1'b0;
    wr_reg(8'h08, 8'hAA);
    repeat (3) step();
    dm_wready = 1'b1; reg_addr = 8'h08;
    repeat (3) step();

    // R4: pointer write in the acceptance cycle does not affect that command
    reg_we = 1'b1; reg_addr = 8'h07; reg_wdata = 8'h81;
    cmd_valid = 1'b1; cmd_last = 1'b0; pc = 12'h300; cmd_dst = 8'h11;
    step(); reg_we = 1'b0; cmd_valid = 1'b0;
    repeat (4) step();

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cmd_valid = (r < 35);
      cmd_last  = $urandom_range(0, 1) == 1;
      pc        = 12'($urandom);
      cmd_dst   = 8'($urandom);
      dm_wready = $urandom_range(0, 99) < 65;
      r = $urandom_range(0, 9);
      reg_addr  = (r < 4) ? 8'h07 : (r < 8) ? 8'h08 : 8'($urandom);
      reg_we    = $urandom_range(0, 99) < 20;
      reg_wdata = 8'($urandom);
      step();
    end
    cmd_valid = 1'b0; reg_we = 1'b0; dm_wready = 1'b1;
    repeat (5) step();
    finish_run();
  end
endmodule